// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the first bytes of each received Ethernet frame on a byte-wide stream and decides whether the frame should be kept. The first byte of a frame is flagged with a start-of-packet marker. The block gathers the destination address from those bytes and classifies it in one of three ways: the all-ones broadcast address, a group (multicast) address, or an individual (unicast) address. It then gives a keep or drop verdict together with a one-cycle valid strobe.

Individual addresses must match a configured station address exactly. Broadcast frames depend only on their own enable. Other group addresses pass through a 64-entry hash table, indexed by CRC bits, when multicast filtering is switched on. Because the hash table can admit addresses that were not intended, downstream software has to confirm group membership itself.

The verdict stays on the output until the next frame begins. Downstream buffering logic can therefore sample it at any point during the payload.

Top module: `dst_addr_filter`

## Requirements
- R1: While `rst` is high, and after it falls until the first verdict, `verdict_valid` and `verdict_accept` are 0.
- R2: The address is taken from the first six bytes that have `rx_valid` high, beginning with a byte that has `rx_sop` high. The first byte on the wire corresponds to `cfg_station_addr[47:40]`, and the last corresponds to `[7:0]`. The block ignores cycles with `rx_valid` low, bytes after the sixth, and valid bytes that arrive while no frame has been opened by `rx_sop` since reset.
- R3: `verdict_valid` is high for exactly one cycle: the cycle right after the edge that samples the sixth address byte. It is low while that byte is presented.
- R4: An address whose group bit is 0 is accepted only if it equals `cfg_station_addr`. The group bit is bit 0 of the first byte, which is address bit 40. Configuration inputs are read in the cycle that `verdict_valid` is high.
- R5: The all-ones address is accepted exactly when `cfg_bcast_en` is 1. This holds whatever the values of `cfg_mcast_en` and the hash table, and the broadcast check takes priority over the hash lookup.
- R6: A group address other than all-ones is rejected when `cfg_mcast_en` is 0.
- R7: With `cfg_mcast_en` at 1, a group address other than all-ones is accepted exactly when `cfg_hash_table[idx]` is 1. Here `idx` is bits 31:26 of a CRC-32 computed over the six bytes in wire order. The CRC runs as follows: start value 0xFFFFFFFF; each byte is taken least significant bit first; each bit step shifts the register right and, when bit 0 XOR the data bit is 1, XORs in 0xEDB88320. No final inversion is applied.
- R8: `verdict_accept` keeps its verdict value until a byte with `rx_sop` is sampled. From the cycle after that it reads 0 until the next verdict.
- R9: A byte with `rx_sop` that arrives part way through an address discards the bytes gathered so far and starts a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte on `rx_byte` is valid this cycle |
| rx_sop | input | 1 | Valid byte is the first byte of a frame |
| rx_byte | input | 8 | Received byte |
| cfg_station_addr | input | 48 | Station address, first wire byte in bits 47:40 |
| cfg_mcast_en | input | 1 | Enable hash-table admission of group addresses |
| cfg_bcast_en | input | 1 | Enable admission of the all-ones address |
| cfg_hash_table | input | 64 | One admit bit per hash index |
| verdict_valid | output | 1 | One-cycle strobe marking a new verdict |
| verdict_accept | output | 1 | 1 = keep frame; held until next start of frame |

## Verification
The bench builds the filter with its default six address bytes and a six-bit hash index. This keeps the whole 64-entry table and all 48 station address bits small enough to sweep one by one. For each unicast case, every single-bit deviation from the station address is sent, including the flip that turns it into a group address. For each of 64 generated group addresses, the bench computes the hash index arithmetically and tries a one-hot table, its complement and the disabled case. Broadcast is crossed with both enables, and the stream is broken up by idle gaps, payload bytes, stray bytes that arrive without a start marker, and restarts in mid-address.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int unsigned OCTET_W = 8;
    localparam int unsigned CRC_W   = 32;

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        CLS_UNICAST   = 2'd0,
        CLS_MULTICAST = 2'd1,
        CLS_BROADCAST = 2'd2
    } addr_class_e;

    typedef struct packed {
        addr_class_e cls;
        logic        hit;
    } verdict_t;

    // Advance a reflected CRC-32 register by one octet, LSB first.
    function automatic logic [CRC_W-1:0] crc_octet(
        input logic [CRC_W-1:0]   crc_in,
        input logic [OCTET_W-1:0] octet
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < OCTET_W; i++) begin
            if (c[0] ^ octet[i]) begin
                c = (c >> 1) ^ CRC_POLY_REFL;
            end else begin
                c = c >> 1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/daf_addr_capture.sv
module daf_addr_capture
    import daf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_BITS  = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          in_sop,
    input  logic [OCTET_W-1:0]            in_octet,
    output logic [ADDR_BYTES*OCTET_W-1:0] addr_q,
    output logic [HASH_BITS-1:0]          hash_idx,
    output logic                          done_q
);

    localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
    localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    // 0: no frame opened; 1..ADDR_BYTES-1: gathering; ADDR_BYTES: complete.
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q;
    logic             take_first;
    logic             take_more;

    assign take_first = in_valid && in_sop;
    assign take_more  = in_valid && !in_sop && (cnt_q != '0) && (cnt_q < CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            addr_q <= '0;
            crc_q  <= CRC_SEED;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (take_first) begin
                cnt_q  <= CNT_W'(1);
                addr_q <= (addr_q << OCTET_W) | ADDR_W'(in_octet);
                crc_q  <= crc_octet(CRC_SEED, in_octet);
                done_q <= (ADDR_BYTES == 1);
            end else if (take_more) begin
                cnt_q  <= cnt_q + CNT_W'(1);
                addr_q <= (addr_q << OCTET_W) | ADDR_W'(in_octet);
                crc_q  <= crc_octet(crc_q, in_octet);
                done_q <= (cnt_q == CNT_LAST);
            end
        end
    end

    assign hash_idx = crc_q[CRC_W-1 -: HASH_BITS];

endmodule

// File: rtl/daf_classify.sv
module daf_classify
    import daf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_BITS  = 6
) (
    input  logic [ADDR_BYTES*OCTET_W-1:0] addr,
    input  logic [HASH_BITS-1:0]          hash_idx,
    input  logic [ADDR_BYTES*OCTET_W-1:0] station,
    input  logic                          mcast_en,
    input  logic                          bcast_en,
    input  logic [(1<<HASH_BITS)-1:0]     hash_table,
    output verdict_t                      verdict
);

    localparam int unsigned ADDR_W    = ADDR_BYTES * OCTET_W;
    localparam int unsigned GROUP_BIT = ADDR_W - OCTET_W;

    logic [ADDR_BYTES-1:0] octet_ones;
    logic [ADDR_BYTES-1:0] octet_same;
    logic                  is_bcast;
    logic                  is_group;
    logic                  is_match;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_octet
        assign octet_ones[g] = &addr[g*OCTET_W +: OCTET_W];
        assign octet_same[g] = (addr[g*OCTET_W +: OCTET_W] == station[g*OCTET_W +: OCTET_W]);
    end

    assign is_bcast = &octet_ones;
    assign is_group = addr[GROUP_BIT];
    assign is_match = &octet_same;

    always_comb begin
        verdict.cls = CLS_UNICAST;
        verdict.hit = is_match;
        if (is_bcast) begin
            verdict.cls = CLS_BROADCAST;
            verdict.hit = bcast_en;
        end else if (is_group) begin
            verdict.cls = CLS_MULTICAST;
            verdict.hit = mcast_en && hash_table[hash_idx];
        end
    end

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_BITS  = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rx_valid,
    input  logic                         rx_sop,
    input  logic [7:0]                   rx_byte,
    input  logic [ADDR_BYTES*8-1:0]      cfg_station_addr,
    input  logic                         cfg_mcast_en,
    input  logic                         cfg_bcast_en,
    input  logic [(1<<HASH_BITS)-1:0]    cfg_hash_table,
    output logic                         verdict_valid,
    output logic                         verdict_accept
);

    localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;

    logic [ADDR_W-1:0]    cap_addr;
    logic [HASH_BITS-1:0] hash_idx;
    logic                 cap_done;
    verdict_t             verdict;
    logic                 hold_q;

    daf_addr_capture #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_BITS  (HASH_BITS)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_sop   (rx_sop),
        .in_octet (rx_byte),
        .addr_q   (cap_addr),
        .hash_idx (hash_idx),
        .done_q   (cap_done)
    );

    daf_classify #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_BITS  (HASH_BITS)
    ) u_cls (
        .addr       (cap_addr),
        .hash_idx   (hash_idx),
        .station    (cfg_station_addr),
        .mcast_en   (cfg_mcast_en),
        .bcast_en   (cfg_bcast_en),
        .hash_table (cfg_hash_table),
        .verdict    (verdict)
    );

    // Verdict register: cleared by a new frame, loaded when an address completes.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (rx_valid && rx_sop) begin
            hold_q <= 1'b0;
        end else if (cap_done) begin
            hold_q <= verdict.hit;
        end
    end

    assign verdict_valid  = cap_done;
    assign verdict_accept = cap_done ? verdict.hit : hold_q;

endmodule

// File: rtl/daf_checker.sv
module daf_checker
    import daf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          rx_valid,
    input logic                          rx_sop,
    input logic [ADDR_BYTES*OCTET_W-1:0] cfg_station_addr,
    input logic                          cfg_mcast_en,
    input logic                          cfg_bcast_en,
    input logic                          verdict_valid,
    input logic                          verdict_accept,
    input logic [ADDR_BYTES*OCTET_W-1:0] cap_addr,
    input addr_class_e                   cls
);

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |=> !verdict_valid);

    a_r3_after_byte: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(rx_valid));

    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!verdict_valid && !$past(rx_valid && rx_sop)) |-> $stable(verdict_accept));

    a_r8_sop_clears: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sop) |=> (verdict_valid || !verdict_accept));

    a_r5_broadcast: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && cls == CLS_BROADCAST) |-> (verdict_accept == cfg_bcast_en));

    a_r5_class_ones: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> ((cls == CLS_BROADCAST) == (&cap_addr)));

    a_r6_mcast_off: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && cls == CLS_MULTICAST && !cfg_mcast_en) |-> !verdict_accept);

    a_r4_unicast: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && cls == CLS_UNICAST) |-> (verdict_accept == (cap_addr == cfg_station_addr)));

endmodule

bind dst_addr_filter daf_checker #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .rx_valid         (rx_valid),
    .rx_sop           (rx_sop),
    .cfg_station_addr (cfg_station_addr),
    .cfg_mcast_en     (cfg_mcast_en),
    .cfg_bcast_en     (cfg_bcast_en),
    .verdict_valid    (verdict_valid),
    .verdict_accept   (verdict_accept),
    .cap_addr         (cap_addr),
    .cls              (verdict.cls)
);

// File: tb/sim_dst_addr_filter.sv
module sim_dst_addr_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic        rx_sop = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [47:0] st = 48'h02_1A_2B_3C_4D_5E;
    logic        men = 1'b0;
    logic        ben = 1'b1;
    logic [63:0] tbl = '0;
    logic        verdict_valid;
    logic        verdict_accept;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    dst_addr_filter u0 (
        .clk              (clk),
        .rst              (rst),
        .rx_valid         (rx_valid),
        .rx_sop           (rx_sop),
        .rx_byte          (rx_byte),
        .cfg_station_addr (st),
        .cfg_mcast_en     (men),
        .cfg_bcast_en     (ben),
        .cfg_hash_table   (tbl),
        .verdict_valid    (verdict_valid),
        .verdict_accept   (verdict_accept)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  o;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            o = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                fb = c[0] ^ o[j];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] a);
        if (a == 48'hFFFF_FFFF_FFFF) return ben;
        if (a[40]) return men && tbl[ref_idx(a)];
        return a == st;
    endfunction

    task automatic push(input logic [7:0] b, input logic sop);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_sop   = sop;
        rx_byte  = b;
    endtask

    task automatic idle();
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sop   = 1'b0;
        rx_byte  = 8'hFF;
    endtask

    // Send six address bytes, optional idle gap between bytes, then check verdict.
    task automatic send_frame(input logic [47:0] a, input int gap, input string tag);
        logic e;
        e = ref_accept(a);
        for (int i = 0; i < 6; i++) begin
            push(a[47-8*i -: 8], i == 0);
            if (i == 5) check("R3 no strobe with sixth byte", verdict_valid, 1'b0);
            if (i < 5) begin
                for (int g = 0; g < gap; g++) idle();
            end
        end
        idle();
        check("R3 strobe after sixth byte", verdict_valid, 1'b1);
        check(tag, verdict_accept, e);
        idle();
        check("R3 strobe one cycle", verdict_valid, 1'b0);
        check("R8 verdict held", verdict_accept, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got running expected finished");
        summary();
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  ix;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", verdict_valid, 1'b0);
        check("R1 accept in reset", verdict_accept, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", verdict_valid, 1'b0);
        check("R1 accept after reset", verdict_accept, 1'b0);

        // R2: station bytes without any start marker are ignored
        for (int i = 0; i < 6; i++) push(st[47-8*i -: 8], 1'b0);
        for (int k = 0; k < 3; k++) begin
            idle();
            check("R2 no frame without sop (valid)", verdict_valid, 1'b0);
            check("R2 no frame without sop (accept)", verdict_accept, 1'b0);
        end

        // R4: exact match, then every single-bit deviation
        send_frame(st, 0, "R4 exact station match");
        for (int b = 0; b < 48; b++) begin
            a = st;
            a[b] = ~a[b];
            send_frame(a, 0, (b == 40) ? "R6 group flip rejected" : "R4 single-bit mismatch");
        end

        // R2: idle gaps inside the address
        send_frame(st, 2, "R2 gaps between bytes");

        // R2/R8: payload bytes leave the verdict alone
        for (int k = 0; k < 12; k++) begin
            push(st[47-8*(k%6) -: 8], 1'b0);
            check("R2 payload no strobe", verdict_valid, 1'b0);
            check("R8 payload keeps accept", verdict_accept, 1'b1);
        end
        idle();

        // R8: start marker clears the held verdict
        push(8'h77, 1'b1);
        check("R8 accept before sop edge", verdict_accept, 1'b1);
        idle();
        check("R8 cleared after sop", verdict_accept, 1'b0);
        check("R8 no strobe on clear", verdict_valid, 1'b0);

        // R9: restart mid-address
        ben = 1'b0;
        for (int i = 0; i < 3; i++) push(8'hFF, i == 0);
        send_frame(st, 0, "R9 restart then station");
        for (int i = 0; i < 4; i++) push(st[47-8*i -: 8], i == 0);
        send_frame(48'h04_11_22_33_44_55, 0, "R9 restart then stranger");

        // R5: broadcast across both enables and table extremes
        for (int k = 0; k < 8; k++) begin
            ben = k[0];
            men = k[1];
            tbl = k[2] ? '1 : '0;
            send_frame(48'hFFFF_FFFF_FFFF, 0, "R5 broadcast");
        end

        // R6/R7: hash lookup sweep over generated group addresses
        for (int k = 0; k < 64; k++) begin
            a = {8'h01 | 8'(k << 2), 8'h00, 8'h5E, 8'(k), 8'(k * 7), 8'(k * 13 + 3)};
            ix = ref_idx(a);
            men = 1'b1;
            tbl = 64'd1 << ix;
            send_frame(a, 0, "R7 hash bit set");
            tbl = ~(64'd1 << ix);
            send_frame(a, k % 2, "R7 hash bit clear");
            men = 1'b0;
            tbl = '1;
            send_frame(a, 0, "R6 multicast disabled");
        end

        // back-to-back: new frame right after a verdict
        men = 1'b0;
        ben = 1'b1;
        send_frame(st, 0, "R4 station after sweep");
        send_frame(48'hFFFF_FFFF_FFFF, 0, "R5 broadcast enabled");

        summary();
    end

endmodule